// File: doc/BRIEF.md
# Region-Gated Channel Enable Register Bank

This block keeps an eight-bit vector of channel enables for a small DMA-style controller and puts it on a plain register bus. Software never rewrites the whole vector. It writes ones to a set alias to turn channels on, and ones to a clear alias to turn them off. Because of this, two software agents can each change their own channels without a read-modify-write race. Both aliases are write-only. The live vector is read from a separate state register and also drives the `ch_enable` output continuously.

The same registers appear in five views. One is a global view. The other four are shadow views, one for each region. Each region has an access mask that says which channels the region owns. A set or clear write made through a shadow view can only change channels the region owns, and a state read through a shadow view shows only those channels. The access masks can be written and read only through the global view.

The word address has two fields. The view field is `addr[5:3]`: 0 selects the global view, 1 to 4 select the shadow views for regions 0 to 3, and 5 to 7 are unmapped. The slot field is `addr[2:0]`: 0 is state (read-only), 1 is set (write-only), 2 is clear (write-only), and 4 to 7 are the access masks of regions 0 to 3 (global view only).

Top module: `chan_enable_bank`

## Requirements
- R1: After reset, `ch_enable`, every access mask and `rd_data` are zero.
- R2: A global write to slot 1 sets every channel whose data bit is 1, and data bits that are 0 change nothing. `ch_enable` shows the result after the write's clock edge. Without a write, `ch_enable` holds its value.
- R3: A global write to slot 2 clears every channel whose data bit is 1, and data bits that are 0 change nothing.
- R4: A slot 1 write through shadow view r sets only the channels that are 1 in both the data and region r's access mask.
- R5: A slot 2 write through shadow view r clears only the channels that are 1 in both the data and region r's access mask.
- R6: A read of slot 1 or slot 2, in any view, returns zero.
- R7: A slot 0 read returns the full enable vector in the global view, and the vector ANDed with region r's mask in shadow view r.
- R8: Access mask slots 4 to 7 can be written and read in the global view. Through a shadow view they read zero, and writes to them are ignored.
- R9: `rd_data` is updated at the clock edge on which `rd_en` is high. It holds its value while `rd_en` is low.
- R10: In views 5 to 7, writes are ignored and reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 6 | Word address: view in bits 5:3, slot in bits 2:0 |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data, one bit per channel |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| ch_enable | output | 8 | Live channel enable vector |

## Verification
A write lands in the enable vector or an access mask at the same clock edge that samples `wr_en`, so `ch_enable` holds the new value one cycle after the write is driven. A read is captured at the edge that samples `rd_en`, so `rd_data` is due one cycle after the request. The bench drives every stimulus on the falling edge and samples on the next falling edge, so it checks exactly one rising edge after each stimulus. It also holds `rd_en` low for a few cycles to confirm that a read result stays in place until the next read.

// File: rtl/ceb_pkg.sv
package ceb_pkg;
  typedef enum logic [2:0] {
    SLOT_NONE,
    SLOT_STATE,
    SLOT_SET,
    SLOT_CLR,
    SLOT_MASK
  } slot_kind_t;

  localparam int unsigned MASK_BASE = 4;
endpackage

// File: rtl/ceb_decode.sv
module ceb_decode
  import ceb_pkg::*;
#(
  parameter int unsigned NUM_REGION = 4,
  parameter int unsigned VIEW_W     = 3,
  parameter int unsigned SLOT_W     = 3,
  parameter int unsigned RIDX_W     = 2
) (
  input  logic [VIEW_W+SLOT_W-1:0] addr,
  output slot_kind_t               kind,
  output logic                     is_global,
  output logic [RIDX_W-1:0]        region,
  output logic [RIDX_W-1:0]        mask_idx
);
  logic [VIEW_W-1:0] view;
  logic [SLOT_W-1:0] slot;
  logic              shadow_hit;
  logic              mask_hit;

  assign view = addr[VIEW_W+SLOT_W-1:SLOT_W];
  assign slot = addr[SLOT_W-1:0];

  always_comb begin
    shadow_hit = 1'b0;
    region     = '0;
    for (int r = 0; r < NUM_REGION; r++) begin
      if (int'(view) == r + 1) begin
        shadow_hit = 1'b1;
        region     = RIDX_W'(r);
      end
    end
  end

  always_comb begin
    mask_hit = 1'b0;
    mask_idx = '0;
    for (int r = 0; r < NUM_REGION; r++) begin
      if (int'(slot) == int'(MASK_BASE) + r) begin
        mask_hit = 1'b1;
        mask_idx = RIDX_W'(r);
      end
    end
  end

  assign is_global = (view == '0);

  always_comb begin
    kind = SLOT_NONE;
    if (is_global || shadow_hit) begin
      if (slot == SLOT_W'(0))      kind = SLOT_STATE;
      else if (slot == SLOT_W'(1)) kind = SLOT_SET;
      else if (slot == SLOT_W'(2)) kind = SLOT_CLR;
      else if (mask_hit && is_global) kind = SLOT_MASK;
    end
  end
endmodule

// File: rtl/ceb_mask_bank.sv
module ceb_mask_bank #(
  parameter int unsigned NUM_CH     = 8,
  parameter int unsigned NUM_REGION = 4,
  parameter int unsigned RIDX_W     = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_hit,
  input  logic [RIDX_W-1:0]                     wr_idx,
  input  logic [NUM_CH-1:0]                     wr_data,
  output logic [NUM_REGION-1:0][NUM_CH-1:0]     masks
);
  for (genvar g = 0; g < NUM_REGION; g++) begin : g_region
    always_ff @(posedge clk) begin
      if (!rst_n)
        masks[g] <= '0;
      else if (wr_hit && (int'(wr_idx) == g))
        masks[g] <= wr_data;
    end
  end
endmodule

// File: rtl/ceb_enable_core.sv
module ceb_enable_core #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_vec,
  input  logic [NUM_CH-1:0] clr_vec,
  output logic [NUM_CH-1:0] state
);
  always_ff @(posedge clk) begin
    if (!rst_n) state <= '0;
    else        state <= (state & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/chan_enable_bank.sv
module chan_enable_bank
  import ceb_pkg::*;
#(
  parameter int unsigned NUM_CH     = 8,
  parameter int unsigned NUM_REGION = 4,
  localparam int unsigned VIEW_W    = $clog2(NUM_REGION + 1),
  localparam int unsigned SLOT_W    = $clog2(MASK_BASE + NUM_REGION),
  localparam int unsigned ADDR_W    = VIEW_W + SLOT_W,
  localparam int unsigned RIDX_W    = (NUM_REGION > 1) ? $clog2(NUM_REGION) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [NUM_CH-1:0] wr_data,
  input  logic              rd_en,
  output logic [NUM_CH-1:0] rd_data,
  output logic [NUM_CH-1:0] ch_enable
);
  slot_kind_t                           kind;
  logic                                 is_global;
  logic [RIDX_W-1:0]                    region;
  logic [RIDX_W-1:0]                    mask_idx;
  logic [NUM_REGION-1:0][NUM_CH-1:0]    access_mask;
  logic [NUM_CH-1:0]                    gate;
  logic [NUM_CH-1:0]                    set_vec;
  logic [NUM_CH-1:0]                    clr_vec;
  logic [NUM_CH-1:0]                    rd_value;

  ceb_decode #(
    .NUM_REGION(NUM_REGION), .VIEW_W(VIEW_W), .SLOT_W(SLOT_W), .RIDX_W(RIDX_W)
  ) u_decode (
    .addr(addr), .kind(kind), .is_global(is_global),
    .region(region), .mask_idx(mask_idx)
  );

  ceb_mask_bank #(
    .NUM_CH(NUM_CH), .NUM_REGION(NUM_REGION), .RIDX_W(RIDX_W)
  ) u_masks (
    .clk(clk), .rst_n(rst_n),
    .wr_hit(wr_en && (kind == SLOT_MASK)),
    .wr_idx(mask_idx), .wr_data(wr_data), .masks(access_mask)
  );

  // Global view owns every channel; a shadow view owns its region's mask.
  assign gate    = is_global ? '1 : access_mask[region];
  assign set_vec = (wr_en && (kind == SLOT_SET)) ? (wr_data & gate) : '0;
  assign clr_vec = (wr_en && (kind == SLOT_CLR)) ? (wr_data & gate) : '0;

  ceb_enable_core #(.NUM_CH(NUM_CH)) u_core (
    .clk(clk), .rst_n(rst_n),
    .set_vec(set_vec), .clr_vec(clr_vec), .state(ch_enable)
  );

  always_comb begin
    case (kind)
      SLOT_STATE: rd_value = ch_enable & gate;
      SLOT_MASK:  rd_value = access_mask[mask_idx];
      default:    rd_value = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_value;
  end
endmodule

// File: rtl/ceb_checker.sv
module ceb_checker #(
  parameter int unsigned NUM_CH     = 8,
  parameter int unsigned NUM_REGION = 4,
  parameter int unsigned VIEW_W     = 3,
  parameter int unsigned SLOT_W     = 3
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [VIEW_W+SLOT_W-1:0]          addr,
  input logic                              wr_en,
  input logic [NUM_CH-1:0]                 wr_data,
  input logic                              rd_en,
  input logic [NUM_CH-1:0]                 rd_data,
  input logic [NUM_CH-1:0]                 ch_enable,
  input logic [NUM_REGION-1:0][NUM_CH-1:0] masks
);
  logic [VIEW_W-1:0] view;
  logic [SLOT_W-1:0] slot;
  logic [NUM_CH-1:0] guard;

  assign view = addr[VIEW_W+SLOT_W-1:SLOT_W];
  assign slot = addr[SLOT_W-1:0];

  always_comb begin
    guard = '0;
    for (int r = 0; r < NUM_REGION; r++)
      if (int'(view) == r + 1) guard = masks[r];
  end

  p_global_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && view == '0 && slot == SLOT_W'(1))
      |=> ((ch_enable & $past(wr_data)) == $past(wr_data)));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ch_enable));

  p_global_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && view == '0 && slot == SLOT_W'(2))
      |=> ((ch_enable & $past(wr_data)) == '0));

  // R4 and R5: a shadow write touches only owned channels
  p_shadow_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && view != '0)
      |=> (((ch_enable ^ $past(ch_enable)) & ~$past(guard)) == '0));

  p_wo_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (slot == SLOT_W'(1) || slot == SLOT_W'(2))) |=> (rd_data == '0));

  p_mask_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && view != '0) |=> $stable(masks));

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind chan_enable_bank ceb_checker #(
  .NUM_CH(NUM_CH), .NUM_REGION(NUM_REGION), .VIEW_W(VIEW_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .ch_enable(ch_enable), .masks(access_mask)
);

// File: tb/sim_chan_enable_bank.sv
module sim_chan_enable_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [7:0] ch_enable;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  chan_enable_bank u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .ch_enable(ch_enable)
  );

  // kind: 0 write, 1 read and compare rd_data, 2 compare ch_enable
  // fields: kind[27:26] req[25:22] addr[21:16] data[15:8] expect[7:0]
  localparam int NV = 26;
  localparam logic [27:0] VEC [NV] = '{
    {2'd0, 4'd2,  6'o01, 8'hA5, 8'h00}, // R2 global set
    {2'd2, 4'd2,  6'o00, 8'h00, 8'hA5},
    {2'd0, 4'd2,  6'o01, 8'h00, 8'h00}, // R2 zero bits do nothing
    {2'd2, 4'd2,  6'o00, 8'h00, 8'hA5},
    {2'd1, 4'd7,  6'o00, 8'h00, 8'hA5}, // R7 global state read
    {2'd0, 4'd3,  6'o02, 8'h05, 8'h00}, // R3 global clear
    {2'd2, 4'd3,  6'o00, 8'h00, 8'hA0},
    {2'd1, 4'd6,  6'o01, 8'h00, 8'h00}, // R6 set alias reads zero
    {2'd1, 4'd6,  6'o12, 8'h00, 8'h00}, // R6 shadow clear alias reads zero
    {2'd0, 4'd8,  6'o04, 8'h0F, 8'h00}, // R8 region 0 mask
    {2'd1, 4'd8,  6'o04, 8'h00, 8'h0F},
    {2'd0, 4'd8,  6'o14, 8'hFF, 8'h00}, // R8 shadow mask write ignored
    {2'd1, 4'd8,  6'o04, 8'h00, 8'h0F},
    {2'd1, 4'd8,  6'o14, 8'h00, 8'h00}, // R8 shadow mask slot reads zero
    {2'd0, 4'd4,  6'o11, 8'hFF, 8'h00}, // R4 region 0 set
    {2'd2, 4'd4,  6'o00, 8'h00, 8'hAF},
    {2'd0, 4'd5,  6'o12, 8'hFF, 8'h00}, // R5 region 0 clear
    {2'd2, 4'd5,  6'o00, 8'h00, 8'hA0},
    {2'd0, 4'd4,  6'o21, 8'hFF, 8'h00}, // R4 region 1 owns nothing yet
    {2'd2, 4'd4,  6'o00, 8'h00, 8'hA0},
    {2'd0, 4'd8,  6'o05, 8'hC3, 8'h00}, // R8 region 1 mask
    {2'd0, 4'd4,  6'o21, 8'h3C, 8'h00}, // R4 disjoint from mask
    {2'd2, 4'd4,  6'o00, 8'h00, 8'hA0},
    {2'd0, 4'd4,  6'o21, 8'hFF, 8'h00}, // R4 region 1 set
    {2'd2, 4'd4,  6'o00, 8'h00, 8'hE3},
    {2'd1, 4'd7,  6'o10, 8'h00, 8'h03}  // R7 region 0 state read
  };

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [5:0] a);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(1, ch_enable, 8'h00);
    check(1, rd_data, 8'h00);
    rst_n = 1'b1;
    do_read(6'o07);
    check(1, rd_data, 8'h00);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][27:26])
        2'd0: do_write(VEC[i][21:16], VEC[i][15:8]);
        2'd1: begin
          do_read(VEC[i][21:16]);
          check(int'(VEC[i][25:22]), rd_data, VEC[i][7:0]);
        end
        default: check(int'(VEC[i][25:22]), ch_enable, VEC[i][7:0]);
      endcase
    end

    // R7 shadow and global views of state E3
    do_read(6'o20); check(7, rd_data, 8'hC3);
    do_read(6'o00); check(7, rd_data, 8'hE3);
    // R5 region 1 clear through its mask C3
    do_write(6'o22, 8'h81); check(5, ch_enable, 8'h62);
    do_write(6'o22, 8'h3C); check(5, ch_enable, 8'h62);
    // R10 unmapped views
    do_write(6'o51, 8'hFF); check(10, ch_enable, 8'h62);
    do_write(6'o72, 8'hFF); check(10, ch_enable, 8'h62);
    do_read(6'o50); check(10, rd_data, 8'h00);
    // R9 read result held while rd_en low
    do_read(6'o05);
    @(negedge clk); addr = 6'o00;
    repeat (3) @(negedge clk);
    check(9, rd_data, 8'hC3);
    // R1 mid-run reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check(1, ch_enable, 8'h00);
    check(1, rd_data, 8'h00);
    do_read(6'o05); check(1, rd_data, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule